// File: doc/BRIEF.md
# Microinstruction Step Counter with Display Decode

This block sequences the steps of a microcoded instruction. It holds a 4-bit step number that forms the low part of a microcode ROM address. The number advances by one on every falling edge of the system clock, so any address-driven ROM output settles during the low phase and is stable for logic that is qualified by the high clock phase.

The microcode ends an instruction early by asserting an end-of-instruction bit in its last step. On the next falling edge the counter then returns to step zero instead of incrementing. An active-low reset clears the counter at once, with no clock edge needed, and holds it at zero for as long as reset stays low.

For a front-panel display, the step is also shown as eight one-hot indicator lines driven from the low three bits, plus one extension line for the upper half of the range. Step 8+k is shown as the extension line together with indicator k.

Top module: `step_seq_counter`

## Requirements
- R1: An active-low level on `rst_ni` sets `step_o` to 0 immediately, without waiting for a clock edge.
- R2: While `rst_ni` is low, `step_o` stays at 0 across falling clock edges, whatever the level of `end_instr_i`; after release, the first falling edge with `end_instr_i` low gives step 1.
- R3: With `end_instr_i` low, `step_o` increases by exactly one on each falling edge of `clk_i` and does not change on the rising edge.
- R4: With `end_instr_i` low, step 15 is followed by step 0.
- R5: When `end_instr_i` is high at a falling edge, `step_o` becomes 0 on that edge instead of incrementing, from any step value including 0 and 15.
- R6: Bit k of `step_onehot_o` is 1 exactly when `step_o[2:0]` equals k, so exactly one of its eight bits is 1 at any time.
- R7: `step_ext_o` is 1 exactly when `step_o` is 8 or more (bit 3 of the step set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; the step advances on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low; clears and holds the step |
| end_instr_i | input | 1 | Microcode end-of-instruction bit; forces step 0 at the next falling edge |
| step_o | output | 4 | Current step, low microcode address bits |
| step_onehot_o | output | 8 | One-hot decode of the low three step bits |
| step_ext_o | output | 1 | Set for steps 8 to 15 |

## Verification
The clocked properties sample on the falling edge and assume that `end_instr_i` is stable around that edge, as it is when it comes from a ROM whose address only moves on falling edges. The reset property samples on the rising edge and assumes reset is never released or applied in the same instant as a clock edge. The bench changes `end_instr_i` and `rst_ni` one time unit after a falling edge or after a rising edge, never on an edge, so both assumptions hold throughout.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
  localparam int unsigned STEP_W_DEF = 4;
endpackage

// File: rtl/step_count_core.sv
module step_count_core #(
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_instr_i,
  output logic [STEP_W-1:0] cnt_o
);
  logic [STEP_W-1:0] cnt_q;
  logic [STEP_W-1:0] cnt_d;

  // end of instruction wins over increment; wrap is natural overflow
  always_comb begin
    if (end_instr_i) cnt_d = '0;
    else             cnt_d = cnt_q + STEP_W'(1);
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/step_disp_dec.sv
module step_disp_dec #(
  parameter int unsigned STEP_W = 4,
  localparam int unsigned LOW_W = STEP_W - 1,
  localparam int unsigned IND_W = 1 << LOW_W
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [IND_W-1:0]  onehot_o,
  output logic              ext_o
);
  logic [LOW_W-1:0] low;
  assign low = step_i[LOW_W-1:0];

  for (genvar k = 0; k < IND_W; k++) begin : g_ind
    assign onehot_o[k] = (low == LOW_W'(k));
  end

  assign ext_o = step_i[STEP_W-1];
endmodule

// File: rtl/step_seq_counter.sv
module step_seq_counter
  import step_seq_pkg::*;
#(
  parameter int unsigned STEP_W = STEP_W_DEF,
  localparam int unsigned IND_W = 1 << (STEP_W - 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              end_instr_i,
  output logic [STEP_W-1:0] step_o,
  output logic [IND_W-1:0]  step_onehot_o,
  output logic              step_ext_o
);
  logic [STEP_W-1:0] cnt;

  step_count_core #(.STEP_W(STEP_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .end_instr_i (end_instr_i),
    .cnt_o       (cnt)
  );

  step_disp_dec #(.STEP_W(STEP_W)) u_dec (
    .step_i   (cnt),
    .onehot_o (step_onehot_o),
    .ext_o    (step_ext_o)
  );

  assign step_o = cnt;
endmodule

// File: rtl/step_seq_counter_chk.sv
module step_seq_counter_chk #(
  parameter int unsigned STEP_W = 4,
  localparam int unsigned IND_W = 1 << (STEP_W - 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              end_instr_i,
  input logic [STEP_W-1:0] step_o,
  input logic [IND_W-1:0]  step_onehot_o,
  input logic              step_ext_o
);
  AST_RST_HOLD: assert property (@(posedge clk_i) !rst_ni |-> step_o == '0); // R2
  AST_STEP_INC: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !end_instr_i |=> (step_o - $past(step_o)) == STEP_W'(1)); // R3
  AST_END_ZERO: assert property (@(negedge clk_i) disable iff (!rst_ni)
    end_instr_i |=> step_o == '0); // R5
  AST_ONE_IND: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $countones(step_onehot_o) == 1); // R6
  AST_IND_POS: assert property (@(negedge clk_i) disable iff (!rst_ni)
    step_onehot_o[step_o[STEP_W-2:0]]); // R6
  AST_EXT_UPPER: assert property (@(negedge clk_i) disable iff (!rst_ni)
    step_ext_o == (step_o >= STEP_W'(IND_W))); // R7
endmodule

bind step_seq_counter step_seq_counter_chk #(.STEP_W(STEP_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .end_instr_i   (end_instr_i),
  .step_o        (step_o),
  .step_onehot_o (step_onehot_o),
  .step_ext_o    (step_ext_o)
);

// File: tb/step_seq_counter_tb.sv
`timescale 1ns/1ps
module step_seq_counter_tb;
  logic       clk = 1'b1;
  logic       rst_n = 1'b0;
  logic       end_instr = 1'b0;
  logic [3:0] step;
  logic [7:0] onehot;
  logic       ext;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  step_seq_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .end_instr_i(end_instr),
    .step_o(step), .step_onehot_o(onehot), .step_ext_o(ext)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic restart();
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    end_instr = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 reset step", int'(step), 0);
    for (int i = 0; i < 3; i++) begin
      end_instr = i[0];
      tick();
      check("R2 held in reset", int'(step), 0);
    end
    end_instr = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    tick();
    check("R2 first step after release", int'(step), 1);
    tick(); tick(); tick();
    check("R3 count to 4", int'(step), 4);
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    check("R1 async clear mid-cycle", int'(step), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic t_count();
    restart();
    for (int i = 1; i <= 20; i++) begin
      tick();
      check(i == 16 ? "R4 wrap 15 to 0" : "R3 increment", int'(step), i % 16);
      @(posedge clk); #1;
      check("R3 no change on rising edge", int'(step), i % 16);
    end
  endtask

  task automatic t_end();
    int tgt [5] = '{0, 2, 5, 7, 15};
    foreach (tgt[j]) begin
      restart();
      for (int i = 0; i < tgt[j]; i++) tick();
      check("R5 reach target", int'(step), tgt[j]);
      end_instr = 1'b1;
      tick();
      check("R5 end forces zero", int'(step), 0);
      end_instr = 1'b0;
      tick();
      check("R5 resume after end", int'(step), 1);
    end
  endtask

  task automatic t_decode();
    restart();
    for (int s = 0; s < 16; s++) begin
      check("R6 one-hot decode", int'(onehot), 1 << (s % 8));
      check("R7 extension flag", int'(ext), s >= 8 ? 1 : 0);
      tick();
    end
  endtask

  initial begin
    t_reset();
    t_count();
    t_end();
    t_decode();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule